// File: doc/BRIEF.md
# Prescaled 16-bit Reference-Compare Timer Channel

This block is a single channel of a general-purpose timer. A 16-bit up-counter advances on ticks that come from a selectable clock source. The tick then passes through two cascaded 8-bit dividers: a primary one and a secondary one. A fixed divide-by-16 path can be selected as the source for long periods. On every counter tick the counter is compared with a 16-bit reference value. On a match the counter either restarts from zero or runs on, and a sticky event flag is set. That flag, gated by an enable bit, drives the interrupt line.

Software programs the channel over a simple register bus. Writes are synchronous and reads are combinational. The usual reprogramming order is: stop and reset the channel, release reset while keeping stop, load the dividers and the mode, clear the counter, load the reference, clear the events, and finally release stop. The stop and reset bits sit in an 8-bit control byte that two channels share. A parameter selects which bit pair belongs to this channel. A second parameter removes the primary divider.

Top module: `ref_timer_ch`

## Requirements
- R1: Mode bits 2:1 select the tick source. Code 1 ticks every clock. Code 2 ticks once every 16 clocks (slow mode). Codes 0 (neighbour cascade, not connected here) and 3 never advance the counter.
- R2: The counter advances once per (P+1)×(S+1) source ticks. S is mode bits 15:8, and P is bits 7:0 of the prescale register at address 4.
- R3: With HAS_PRIMARY=0 the divide is (S+1) alone, and the prescale register reads 0.
- R4: When mode bit 3 is set, a counter tick taken while the counter equals the reference loads zero instead of incrementing.
- R5: When mode bit 3 is clear, the counter increments past the reference and wraps from 0xFFFF to 0. It raises no event unless the reference is 0.
- R6: A counter tick taken while the counter equals the reference sets event bit 1. Every other event bit reads 0.
- R7: Writing the event register (address 3) clears each set bit where the written data has a one. A clear and a new match in the same cycle leave bit 1 set.
- R8: irq_o is event bit 1 ANDed with mode bit 4, and it stays high until the flag is cleared.
- R9: Control register (address 5): stop is bit 1 and reset is bit 0 when CH_HI=0, or bits 5 and 4 when CH_HI=1. Other bits are ignored and read 0. After rst_ni, stop reads 1. While stop is set, the counter and the divider states hold.
- R10: While the reset bit is set, the counter and all divider states are held at zero.
- R11: Writing the counter register (address 2) loads the counter directly in that cycle.
- R12: Register map: mode at 0, reference at 1, counter at 2, events at 3, prescale at 4, control at 5. All registers read 0 after rst_ni, except the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Reference-match interrupt |

## Verification
The counting path is exercised with the internal source at divide 1, with both dividers set to distinct ratios, with slow mode, and with the idle source codes. Each pattern is run for a set number of enabled cycles, so the final count reveals whether the ratio is a product, a sum, or is missing a stage. A second instance with the primary divider removed and the upper control bit pair receives the same traffic, which separates the two build variants. Restart and free-run are checked against a small reference and across the 0xFFFF wrap with the reference both nonzero and zero, which tells a true compare apart from an overflow event. A clear write timed onto a match edge, and stop and reset windows placed between runs, distinguish hold from clear and confirm that set takes priority over clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int CTL_W  = 8;
  localparam int EVT_REF_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_REF  = 3'd1,
    A_CNT  = 3'd2,
    A_EVT  = 3'd3,
    A_PSC  = 3'd4,
    A_CTL  = 3'd5
  } addr_e;

  typedef enum logic [1:0] {
    SRC_CASC = 2'd0,
    SRC_INT  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef struct packed {
    logic [7:0] sps;
    logic [2:0] rsv_hi;
    logic       ien;
    logic       restart;
    src_e       src;
    logic       rsv_lo;
  } mode_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter bit HAS_PRIMARY = 1'b1,
  parameter bit CH_HI       = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] ref_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CTL_W-1:0]  ctl_rd_o,
  output logic              stop_o,
  output logic              clr_o,
  output logic              cnt_we_o,
  output logic              evt_we_o
);
  localparam int STP_BIT = CH_HI ? 5 : 1;
  localparam int RST_BIT = CH_HI ? 4 : 0;

  mode_t             mode_q;
  logic [DATA_W-1:0] ref_q;
  logic              stop_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ref_q  <= '0;
      stop_q <= 1'b1;
      clr_q  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        A_MODE: mode_q <= mode_t'(wdata_i);
        A_REF:  ref_q  <= wdata_i;
        A_CTL: begin
          stop_q <= wdata_i[STP_BIT];
          clr_q  <= wdata_i[RST_BIT];
        end
        default: ;
      endcase
    end
  end

  generate
    if (HAS_PRIMARY) begin : g_psc
      logic [PSC_W-1:0] psc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     psc_q <= '0;
        else if (wr_i && addr_i == A_PSC) psc_q <= wdata_i[PSC_W-1:0];
      end
      assign psc_o = psc_q;
    end else begin : g_no_psc
      assign psc_o = '0;
    end
  endgenerate

  always_comb begin
    ctl_rd_o          = '0;
    ctl_rd_o[STP_BIT] = stop_q;
    ctl_rd_o[RST_BIT] = clr_q;
  end

  assign mode_o   = mode_q;
  assign ref_o    = ref_q;
  assign stop_o   = stop_q;
  assign clr_o    = clr_q;
  assign cnt_we_o = wr_i && (addr_i == A_CNT);
  assign evt_we_o = wr_i && (addr_i == A_EVT);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int SLOW_DIV    = 16,
  parameter bit HAS_PRIMARY = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  src_e             src_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [PSC_W-1:0] sps_i,
  output logic             tick_o
);
  localparam int SLOW_W = $clog2(SLOW_DIV);
  localparam logic [SLOW_W-1:0] SLOW_MAX = SLOW_W'(SLOW_DIV - 1);

  logic [SLOW_W-1:0] slow_q;
  logic [PSC_W-1:0]  sec_q;
  logic              src_tick, pri_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          slow_q <= '0;
    else if (clr_i)                       slow_q <= '0;
    else if (run_i && src_i == SRC_SLOW)  slow_q <= (slow_q == SLOW_MAX) ? '0 : slow_q + 1'b1;
  end

  assign src_tick = run_i && !clr_i &&
                    ((src_i == SRC_INT) || (src_i == SRC_SLOW && slow_q == SLOW_MAX));

  generate
    if (HAS_PRIMARY) begin : g_pri
      logic [PSC_W-1:0] pri_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pri_q <= '0;
        else if (clr_i)    pri_q <= '0;
        else if (src_tick) pri_q <= (pri_q >= psc_i) ? '0 : pri_q + 1'b1;
      end
      assign pri_tick = src_tick && (pri_q >= psc_i);
    end else begin : g_nopri
      assign pri_tick = src_tick;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sec_q <= '0;
    else if (clr_i)    sec_q <= '0;
    else if (pri_tick) sec_q <= (sec_q >= sps_i) ? '0 : sec_q + 1'b1;
  end

  assign tick_o = pri_tick && (sec_q >= sps_i);

  assert_tick_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (run_i && !clr_i));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic              cnt_we_i,
  input  logic              evt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              evt_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              evt_q, match;

  assign match = tick_i && (cnt_q == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (cnt_we_i)  cnt_q <= wdata_i;
    else if (tick_i)    cnt_q <= (match && restart_i) ? '0 : cnt_q + 1'b1;
  end

  // set wins over a simultaneous write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= (evt_q && !(evt_we_i && wdata_i[EVT_REF_BIT])) || match;
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;

  assert_rst_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_stop_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i && !cnt_we_i) |=> $stable(cnt_q));
  assert_restart_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && restart_i && cnt_q == ref_i && !clr_i && !cnt_we_i) |=> (cnt_q == '0));
  assert_match_sets_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == ref_i) |=> evt_q);
  assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !clr_i) |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/ref_timer_ch.sv
module ref_timer_ch
  import tmr_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int SLOW_DIV    = 16,
  parameter bit HAS_PRIMARY = 1'b1,
  parameter bit CH_HI       = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_wr_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        irq_o
);
  mode_t             mode;
  logic [DATA_W-1:0] ref_val, cnt;
  logic [PSC_W-1:0]  psc;
  logic [CTL_W-1:0]  ctl_rd;
  logic              stop, clr, cnt_we, evt_we, tick, evt, run;

  tmr_regs #(.PSC_W(PSC_W), .HAS_PRIMARY(HAS_PRIMARY), .CH_HI(CH_HI)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .mode_o(mode), .ref_o(ref_val), .psc_o(psc), .ctl_rd_o(ctl_rd),
    .stop_o(stop), .clr_o(clr), .cnt_we_o(cnt_we), .evt_we_o(evt_we)
  );

  assign run = !stop && !clr;

  tmr_prescale #(.PSC_W(PSC_W), .SLOW_DIV(SLOW_DIV), .HAS_PRIMARY(HAS_PRIMARY)) u_psc (
    .clk_i, .rst_ni,
    .run_i(run), .clr_i(clr), .src_i(mode.src),
    .psc_i(psc), .sps_i(mode.sps), .tick_o(tick)
  );

  tmr_count u_cnt (
    .clk_i, .rst_ni,
    .clr_i(clr), .run_i(run), .tick_i(tick), .restart_i(mode.restart),
    .ref_i(ref_val), .cnt_we_i(cnt_we), .evt_we_i(evt_we), .wdata_i(bus_wdata_i),
    .cnt_o(cnt), .evt_o(evt)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_MODE: bus_rdata_o = mode;
      A_REF:  bus_rdata_o = ref_val;
      A_CNT:  bus_rdata_o = cnt;
      A_EVT:  bus_rdata_o[EVT_REF_BIT] = evt;
      A_PSC:  bus_rdata_o = DATA_W'(psc);
      A_CTL:  bus_rdata_o = DATA_W'(ctl_rd);
      default: ;
    endcase
  end

  assign irq_o = evt && mode.ien;

  assert_irq_needs_ien_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(evt_we && bus_wdata_i[EVT_REF_BIT]) && !(bus_wr_i && bus_addr_i == A_MODE)) |=> irq_o);
endmodule

// File: tb/ref_timer_ch_tb.sv
`timescale 1ns/1ps
module ref_timer_ch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  always #10 clk = ~clk;

  ref_timer_ch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_a), .irq_o(irq_a)
  );
  // variant: no primary divider, upper control bit pair
  ref_timer_ch #(.HAS_PRIMARY(1'b0), .CH_HI(1'b1)) u_dut_np (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_b), .irq_o(irq_b)
  );

  typedef struct {
    int          sel;   // 0 rdata main, 1 rdata variant, 2 irq main
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int pushed_n = 0, popped_n = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] CTL_STOP = 16'h0022, CTL_RUN = 16'h0000,
                          CTL_RST = 16'h0011, CTL_SR = 16'h0033;

  always @(negedge clk) begin
    if (popped_n < pushed_n) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rdata_a;
        1: act = rdata_b;
        default: act = {15'd0, irq_a};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=0x%04h expected=0x%04h", it.tag, act, it.exp);
      end
      popped_n++;
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic chk(input int sel, input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    pushed_n++;
    wait (popped_n == pushed_n);
    @(posedge clk); #1;
  endtask

  task automatic setup(input logic [15:0] mode, input logic [15:0] refv, input logic [15:0] psc);
    wreg(3'd5, CTL_SR);
    wreg(3'd5, CTL_STOP);
    wreg(3'd4, psc);
    wreg(3'd0, mode);
    wreg(3'd2, 16'h0000);
    wreg(3'd1, refv);
    wreg(3'd3, 16'hFFFF);
  endtask

  // exactly n enabled edges
  task automatic run(input int n);
    wreg(3'd5, CTL_RUN);
    repeat (n - 1) @(posedge clk);
    #1;
    wreg(3'd5, CTL_STOP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // reset state, map (R12, R9)
    chk(0, 3'd0, 16'h0000, "R12 mode reset");
    chk(0, 3'd2, 16'h0000, "R12 cnt reset");
    chk(0, 3'd3, 16'h0000, "R12 evt reset");
    chk(0, 3'd5, 16'h0002, "R9 ctl reset low pair");
    chk(1, 3'd5, 16'h0020, "R9 ctl reset high pair");
    chk(2, 3'd0, 16'h0000, "R8 irq reset");
    wreg(3'd4, 16'h0005);
    chk(0, 3'd4, 16'h0005, "R2 psc readback");
    chk(1, 3'd4, 16'h0000, "R3 psc absent reads 0");

    // R1 internal source
    setup(16'h0002, 16'hFFFF, 16'h0000);
    run(20);
    chk(0, 3'd2, 16'd20, "R1 internal cnt");
    chk(1, 3'd2, 16'd20, "R1 internal cnt variant");

    // R2 / R3 dividers
    setup(16'h0102, 16'hFFFF, 16'h0002);
    run(60);
    chk(0, 3'd2, 16'd10, "R2 divide (P+1)(S+1)");
    chk(1, 3'd2, 16'd30, "R3 divide (S+1) only");

    // R1 slow
    setup(16'h0104, 16'hFFFF, 16'h0000);
    run(100);
    chk(0, 3'd2, 16'd3, "R1 slow /16 cnt");

    // R1 idle sources
    setup(16'h0000, 16'hFFFF, 16'h0000);
    run(20);
    chk(0, 3'd2, 16'd0, "R1 cascade code idle");
    setup(16'h0006, 16'hFFFF, 16'h0000);
    run(20);
    chk(0, 3'd2, 16'd0, "R1 code 3 idle");

    // R4 restart
    setup(16'h001A, 16'd4, 16'h0000);
    run(5);
    chk(0, 3'd2, 16'd0, "R4 restart to zero");
    chk(0, 3'd3, 16'h0002, "R6 evt bit1 on match");
    chk(2, 3'd0, 16'h0001, "R8 irq with ien");
    run(3);
    chk(0, 3'd2, 16'd3, "R4 counts again after restart");

    // R8 gating
    wreg(3'd0, 16'h000A);
    chk(2, 3'd0, 16'h0000, "R8 irq masked by ien");
    chk(0, 3'd3, 16'h0002, "R8 flag kept while masked");

    // R7 write-one clear
    wreg(3'd3, 16'h0001);
    chk(0, 3'd3, 16'h0002, "R7 other bit write no clear");
    wreg(3'd3, 16'hFFFD);
    chk(0, 3'd3, 16'h0002, "R7 zero at bit1 keeps flag");
    wreg(3'd3, 16'h0002);
    chk(0, 3'd3, 16'h0000, "R7 one at bit1 clears");

    // R5 free-run
    setup(16'h0012, 16'd4, 16'h0000);
    run(7);
    chk(0, 3'd2, 16'd7, "R5 free-run passes ref");
    chk(0, 3'd3, 16'h0002, "R6 free-run evt");
    chk(2, 3'd0, 16'h0001, "R8 irq free-run");

    // R5 wrap
    setup(16'h0002, 16'd5, 16'h0000);
    wreg(3'd2, 16'hFFFE);
    run(3);
    chk(0, 3'd2, 16'd1, "R5 wrap count");
    chk(0, 3'd3, 16'h0000, "R5 wrap no event");
    setup(16'h0002, 16'd0, 16'h0000);
    wreg(3'd2, 16'hFFFE);
    run(3);
    chk(0, 3'd3, 16'h0002, "R5 wrap event with ref 0");

    // R11 load, R9 hold
    wreg(3'd2, 16'h1234);
    chk(0, 3'd2, 16'h1234, "R11 counter load");
    repeat (10) @(posedge clk);
    #1;
    chk(0, 3'd2, 16'h1234, "R9 stop holds counter");
    setup(16'h0302, 16'hFFFF, 16'h0000);
    run(2);
    repeat (10) @(posedge clk);
    #1;
    run(2);
    chk(0, 3'd2, 16'd1, "R9 stop holds prescaler");

    // R10 reset bit
    wreg(3'd5, CTL_RST);
    repeat (12) @(posedge clk);
    #1;
    chk(0, 3'd2, 16'd0, "R10 reset holds zero");
    wreg(3'd5, CTL_STOP);
    chk(0, 3'd2, 16'd0, "R10 zero after reset");

    // R7 clear and match same cycle
    setup(16'h000A, 16'd2, 16'h0000);
    wreg(3'd2, 16'd2);
    wreg(3'd5, CTL_RUN);
    wreg(3'd3, 16'hFFFF);
    wreg(3'd5, CTL_STOP);
    chk(0, 3'd3, 16'h0002, "R7 set wins over clear");
    chk(0, 3'd2, 16'd1, "R4 restart then count");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule